// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

A clocked digital monostable. A qualified edge on one of three inputs starts an output pulse `pulse` that lasts a programmed number of clock cycles. Its complement is always on `pulse_n`. The three inputs are:

- `edge_lo`, an active-low edge input.
- `edge_hi`, an active-high edge input.
- `stop_n`, an active-low clear. Its release also acts as a trigger.

A fresh qualified edge during a pulse reloads the timer, so the pulse is stretched. A trigger stream faster than the programmed width holds the output high without a break. Holding `stop_n` low cuts the pulse off at once.

The width comes from the `width` input, counted in clock cycles. All inputs are taken to be synchronous to `clk`. Edges are found by comparing each input with its value on the previous clock edge.

Top module: `retrig_pulse`

## Requirements
- R1: A falling edge of `edge_lo` (1 then 0 on consecutive clock edges) while `edge_hi`=1 and `stop_n`=1 sets `pulse` high from the next clock edge.
- R2: A rising edge of `edge_hi` while `edge_lo`=0 and `stop_n`=1 sets `pulse` high from the next clock edge.
- R3: A rising edge of `stop_n` while `edge_lo`=0 and `edge_hi`=1 sets `pulse` high from the next clock edge.
- R4: While `stop_n`=0, `pulse`=0 and `pulse_n`=1 in that same cycle, whatever the other inputs do. The timer is cleared, and a trigger in the same cycle is lost.
- R5: No edge starts a pulse while `edge_lo`=1 or `edge_hi`=0. With no pulse running, `pulse` stays 0.
- R6: After a trigger seen at clock edge k, `pulse` is 1 for exactly max(`width`,1) cycles and 0 from the edge after that. A `width` of 0 behaves as 1.
- R7: A trigger during a pulse reloads the timer, so the pulse ends max(`width`,1) cycles after the latest trigger. Triggers spaced closer than that keep `pulse` continuously high.
- R8: `pulse_n` is always the inverse of `pulse`.
- R9: Synchronous reset `rst` clears the timer and the edge history. `pulse` is 0 after reset, and the first sample after reset cannot produce a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| edge_lo | input | 1 | Trigger on falling edge |
| edge_hi | input | 1 | Trigger on rising edge |
| stop_n | input | 1 | Active-low clear; its rising edge triggers |
| width | input | CNT_W | Pulse width in clock cycles (0 acts as 1) |
| pulse | output | 1 | Timed pulse |
| pulse_n | output | 1 | Inverse of `pulse` |

## Verification
A trigger applied after clock edge c shows on `pulse` in cycle c+1. The pulse stays high through cycle c+W and is low in cycle c+W+1. A low `stop_n` forces the output low within the same cycle c, before any edge. The driver stamps every expected output value with the absolute cycle number derived from these latencies. The monitor compares only at the falling clock edge of that exact cycle, so each check lands on the settled value of the cycle it targets.

// File: rtl/retrig_pulse.sv
module retrig_pulse #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_lo,
  input  logic             edge_hi,
  input  logic             stop_n,
  input  logic [CNT_W-1:0] width,
  output logic             pulse,
  output logic             pulse_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             lo_d, hi_d, stop_d;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] load_val;
  logic             fire;

  assign fire = stop_n & ((lo_d & ~edge_lo & edge_hi) |
                          (~hi_d & edge_hi & ~edge_lo) |
                          (~stop_d & ~edge_lo & edge_hi));

  assign load_val = (width == '0) ? ONE : width;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_d   <= 1'b0;
      hi_d   <= 1'b1;
      stop_d <= 1'b1;
      remain <= '0;
    end else begin
      lo_d   <= edge_lo;
      hi_d   <= edge_hi;
      stop_d <= stop_n;
      if (!stop_n)
        remain <= '0;
      else if (fire)
        remain <= load_val;
      else if (remain != '0)
        remain <= remain - ONE;
    end
  end

  assign pulse   = (remain != '0) & stop_n;
  assign pulse_n = ~pulse;
endmodule

// File: rtl/retrig_pulse_chk.sv
module retrig_pulse_chk (
  input logic clk,
  input logic rst,
  input logic edge_lo,
  input logic edge_hi,
  input logic stop_n,
  input logic pulse,
  input logic pulse_n
);
  assert_fall_trig_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(edge_lo) && edge_hi && stop_n) |=> pulse);

  assert_rise_trig_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(edge_hi) && !edge_lo && stop_n) |=> pulse);

  assert_release_trig_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(stop_n) && !edge_lo && edge_hi) |=> pulse);

  assert_clear_forces_R4: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> (!pulse && pulse_n));

  assert_gated_idle_R5: assert property (@(posedge clk) disable iff (rst)
    ((edge_lo || !edge_hi) && stop_n && !pulse) |=> !pulse);

  assert_reset_low_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pulse);
endmodule

bind retrig_pulse retrig_pulse_chk chk_i (
  .clk(clk), .rst(rst), .edge_lo(edge_lo), .edge_hi(edge_hi),
  .stop_n(stop_n), .pulse(pulse), .pulse_n(pulse_n)
);

// File: tb/retrig_pulse_tb_top.sv
module retrig_pulse_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic edge_lo = 1'b1;
  logic edge_hi = 1'b1;
  logic stop_n = 1'b1;
  logic [CNT_W-1:0] width = 8'd5;
  logic pulse, pulse_n;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    at;
    bit    v;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  retrig_pulse #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .edge_lo(edge_lo), .edge_hi(edge_hi),
    .stop_n(stop_n), .width(width), .pulse(pulse), .pulse_n(pulse_n)
  );

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        checks++;
        if (pulse !== sb[i].v || pulse_n !== ~sb[i].v) begin
          errors++;
          $display("FAIL %s cycle %0d: pulse=%b pulse_n=%b expected pulse=%b pulse_n=%b",
                   sb[i].tag, cyc, pulse, pulse_n, sb[i].v, ~sb[i].v);
        end
        sb.delete(i);
      end
    end
  end

  task automatic drive(input logic l, input logic h, input logic s);
    @(posedge clk);
    #1;
    edge_lo = l;
    edge_hi = h;
    stop_n  = s;
  endtask

  task automatic want(input int at, input bit v, input string tag);
    exp_t e;
    e.at = at; e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic span(input int c, input int w, input string tag);
    for (int k = 1; k <= w; k++) want(c + k, 1'b1, tag);
    want(c + w + 1, 1'b0, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int c;
    idle(3);
    #1 rst = 1'b0;
    want(cyc, 1'b0, "R9");
    want(cyc + 1, 1'b0, "R9");
    idle(3);

    // R1 falling edge_lo, width 5
    drive(0, 1, 1); c = cyc;
    span(c, 5, "R1_R6_R8");
    idle(8);

    // R5 falling edge_hi does nothing; R2 rising edge_hi
    drive(0, 0, 1); want(cyc + 1, 1'b0, "R5");
    drive(0, 1, 1); c = cyc;
    span(c, 5, "R2");
    idle(8);

    // R4 clear then R3 release trigger
    drive(0, 1, 0); want(cyc, 1'b0, "R4"); want(cyc + 1, 1'b0, "R4");
    drive(0, 1, 1); c = cyc;
    span(c, 5, "R3");
    idle(8);

    // R4 abort mid-pulse, release retriggers (R3)
    width = 8'd10;
    drive(0, 0, 1);
    drive(0, 1, 1); c = cyc;
    want(c + 1, 1'b1, "R2"); want(c + 2, 1'b1, "R2");
    drive(0, 1, 1);
    drive(0, 1, 1);
    drive(0, 1, 0); want(c + 3, 1'b0, "R4");
    drive(0, 1, 1); want(c + 4, 1'b0, "R4");
    span(c + 4, 10, "R3");
    idle(14);

    // R4 clear wins over a simultaneous trigger
    drive(1, 1, 1);
    drive(0, 1, 0); c = cyc;
    want(c, 1'b0, "R4"); want(c + 1, 1'b0, "R4");
    drive(1, 1, 1); want(cyc + 1, 1'b0, "R5");
    idle(3);

    // R5 gated edges
    drive(1, 0, 1);
    drive(1, 1, 1); want(cyc + 1, 1'b0, "R5");
    drive(1, 0, 1);
    drive(0, 0, 1); want(cyc + 1, 1'b0, "R5");
    drive(0, 0, 0);
    drive(0, 0, 1); want(cyc + 1, 1'b0, "R5"); want(cyc + 2, 1'b0, "R5");
    idle(3);

    // R6 width 0, 1, 3
    width = 8'd0;
    drive(1, 1, 1);
    drive(0, 1, 1); span(cyc, 1, "R6");
    idle(3);
    width = 8'd1;
    drive(1, 1, 1);
    drive(0, 1, 1); span(cyc, 1, "R6");
    idle(3);
    width = 8'd3;
    drive(0, 0, 1);
    drive(0, 1, 1); span(cyc, 3, "R6");
    idle(5);

    // R7 single retrigger extends
    width = 8'd4;
    drive(0, 0, 1);
    drive(0, 1, 1); c = cyc;
    drive(0, 0, 1);
    drive(0, 0, 1);
    drive(0, 1, 1);
    span(c, 7, "R7");
    idle(8);

    // R7 trigger stream keeps output high
    drive(0, 0, 1);
    drive(0, 1, 1); c = cyc;
    span(c, 12, "R7");
    for (int k = 1; k <= 9; k++) drive(0, (k % 2 == 0), 1);
    drive(0, 0, 1);
    idle(10);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      #800000;
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule